// File: doc/BRIEF.md
# Store Queue with Load Forwarding

This block holds stores between dispatch and commit so that memory is only ever written in program order. A store takes a slot at dispatch and receives an age tag: its queue position plus a wrap bit. When its address, access size and data are known, they are written into that slot. At commit the oldest slot is handed to the memory write port and freed.

A load asks the queue in the cycle it has its address. It supplies the address, the access size and its age, which is the tag the next store would have received when the load was dispatched. The queue looks at every store older than the load that covers at least one of the same bytes. For each byte it picks the youngest such store. It returns a full 64-bit word in which the bytes taken from stores are merged over the word read from memory, together with a byte mask of the forwarded lanes. A separate flag tells the load that some older store has no address yet, so a conservative scheduler can hold the load back. A flush input drops every store that has not been committed.

Top module: `store_fwd_queue`

## Requirements
- R1: After reset the queue is empty: `alloc_rdy` is 1, `alloc_tag` is 0, and `cm_go` produces no memory write.
- R2: Each accepted allocation returns the current `alloc_tag` and increments it by one. The top bit of the tag is a wrap bit. After DEPTH slots are held, `alloc_rdy` is 0 and allocation requests are ignored. Committing a store frees its slot.
- R3: An access covers 1, 2, 4 or 8 bytes for size code 0, 1, 2 or 3. Its byte lanes within the 8-byte word start at the address low three bits rounded down to a multiple of the access size. Store data is given in those lanes and bytes outside them are discarded.
- R4: For each byte of the load, the queue selects among the older stores with a known address in the same 8-byte word that cover that byte, and takes the byte from the youngest of them. Bit b of `ld_fwd_be` marks lane b as forwarded. Stores in other words or on disjoint lanes forward nothing.
- R5: A store whose age is equal to or younger than `ld_age` takes no part in the search.
- R6: A byte that is not forwarded is taken from `mem_rd_data`. One result may merge bytes from several stores and from memory.
- R7: `ld_unknown` is 1 exactly when an older store has no address yet. Such a store forwards nothing.
- R8: While `cm_go` is high and the oldest slot has its address, `mem_wr_en` is high in that cycle and carries that store's word address, byte enables and lane data, and the slot is released. If the oldest slot is empty or has no address yet, `cm_go` has no effect.
- R9: Flush frees every slot not committed in the same cycle. The next tag is the oldest remaining position. A reallocated slot carries no address from an earlier occupant.
- R10: While `ld_vld` is low, `ld_fwd_be` is 0, `ld_unknown` is 0 and `ld_data` equals `mem_rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_vld | input | 1 | Request a slot for a new store |
| alloc_rdy | output | 1 | A slot is free |
| alloc_tag | output | PTR_W+1 | Age tag given to the next allocation |
| st_vld | input | 1 | Write address, size and data of a store |
| st_slot | input | PTR_W | Slot index (tag without wrap bit) |
| st_addr | input | ADDR_W | Store byte address |
| st_size | input | 2 | Store size code |
| st_data | input | 64 | Store data in byte lanes |
| ld_vld | input | 1 | Load search request |
| ld_addr | input | ADDR_W | Load byte address |
| ld_size | input | 2 | Load size code |
| ld_age | input | PTR_W+1 | Tag that was next when the load was dispatched |
| mem_rd_data | input | 64 | Memory word for the load address |
| ld_data | output | 64 | Merged load word |
| ld_fwd_be | output | 8 | Lanes supplied by stores |
| ld_unknown | output | 1 | An older store has no address yet |
| cm_go | input | 1 | Commit the oldest store |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wr_addr | output | ADDR_W | Word-aligned write address |
| mem_wr_be | output | 8 | Write byte enables |
| mem_wr_data | output | 64 | Write data in lanes |
| flush | input | 1 | Drop all uncommitted stores |

## Verification
Four overlapping stores are queued: a full word, an upper half, a middle pair with junk outside its lanes, and a single byte in another word. The same loads are then repeated with different ages. Whole-word loads show the per-byte youngest-wins merge. Moving the age back shows that younger stores are excluded, and a zero age returns plain memory. Narrow and misaligned loads check the range test that uses the access size, and loads to other words or to uncovered lanes must return memory only. Unknown-address stores placed among known ones separate the unknown flag from forwarding. Commits that end on an unknown head, a flush followed by reallocation, and pointer wrap cover the ordering corners.

// File: rtl/sq_pkg.sv
// Shared constants and helpers for the store queue.
// Assumes an 8-byte data word and naturally aligned accesses.
package sq_pkg;
    localparam int LANES = 8;
    localparam int OFF_W = $clog2(LANES);
    localparam int DW    = LANES * 8;

    typedef enum logic [1:0] {
        SZ_B = 2'd0,
        SZ_H = 2'd1,
        SZ_W = 2'd2,
        SZ_D = 2'd3
    } sq_size_e;

    // Byte lanes covered by an access of size code sz at word offset off.
    function automatic logic [LANES-1:0] sz_mask(input logic [OFF_W-1:0] off,
                                                 input logic [1:0] sz);
        logic [3:0]       nb;
        logic [OFF_W-1:0] base;
        logic [15:0]      m;
        nb   = 4'd1 << sz;
        base = off & ~(nb[OFF_W-1:0] - 3'd1);
        m    = ((16'd1 << nb) - 16'd1) << base;
        return m[LANES-1:0];
    endfunction

    // Widen a byte mask to a bit mask.
    function automatic logic [DW-1:0] be2bits(input logic [LANES-1:0] be);
        logic [DW-1:0] r;
        for (int b = 0; b < LANES; b++) r[8*b +: 8] = {8{be[b]}};
        return r;
    endfunction
endpackage

// File: rtl/sq_ptr_ctl.sv
// Head and tail pointers of the queue, each with a wrap bit.
// Assumes DEPTH is a power of two. A flush sets the tail to the head
// after any commit in the same cycle.
module sq_ptr_ctl #(
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           alloc_req,
    input  logic           pop,
    input  logic           flush,
    output logic           alloc_fire,
    output logic           full,
    output logic [PTR_W:0] head,
    output logic [PTR_W:0] tail,
    output logic [PTR_W:0] count
);
    logic [PTR_W:0] head_n;

    // Occupancy and full detection from the pointer difference.
    always_comb begin
        count      = tail - head;
        full       = (count == (PTR_W+1)'(DEPTH));
        alloc_fire = alloc_req && !full && !flush;
        head_n     = head + (PTR_W+1)'(pop);
    end

    // Advance head on commit; advance or rewind tail.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head <= '0;
            tail <= '0;
        end else begin
            head <= head_n;
            if (flush)           tail <= head_n;
            else if (alloc_fire) tail <= tail + 1'b1;
        end
    end
endmodule

// File: rtl/sq_entry_array.sv
// Storage for the queue slots: valid, address-known, word address,
// byte enables and lane data. A fill is accepted only for a held slot.
module sq_entry_array
    import sq_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int WA_W  = ADDR_W - OFF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_fire,
    input  logic [PTR_W-1:0] alloc_idx,
    input  logic             st_vld,
    input  logic [PTR_W-1:0] st_idx,
    input  logic [WA_W-1:0]  st_wadr,
    input  logic [LANES-1:0] st_be,
    input  logic [DW-1:0]    st_data,
    input  logic             pop,
    input  logic [PTR_W-1:0] pop_idx,
    input  logic             flush,
    output logic             vld_o  [DEPTH],
    output logic             akn_o  [DEPTH],
    output logic [WA_W-1:0]  wadr_o [DEPTH],
    output logic [LANES-1:0] be_o   [DEPTH],
    output logic [DW-1:0]    data_o [DEPTH]
);
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        // Slot lifetime: set on allocation, cleared on commit or flush.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_o[i] <= 1'b0;
            end else if (flush) begin
                vld_o[i] <= 1'b0;
            end else if (alloc_fire && alloc_idx == PTR_W'(i)) begin
                vld_o[i] <= 1'b1;
            end else if (pop && pop_idx == PTR_W'(i)) begin
                vld_o[i] <= 1'b0;
            end
        end

        // Address and data capture, cleared again when the slot is reused.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                akn_o[i]  <= 1'b0;
                wadr_o[i] <= '0;
                be_o[i]   <= '0;
                data_o[i] <= '0;
            end else if (alloc_fire && alloc_idx == PTR_W'(i)) begin
                akn_o[i]  <= 1'b0;
            end else if (st_vld && !flush && vld_o[i] && st_idx == PTR_W'(i)) begin
                akn_o[i]  <= 1'b1;
                wadr_o[i] <= st_wadr;
                be_o[i]   <= st_be;
                data_o[i] <= st_data & be2bits(st_be);
            end
        end
    end
endmodule

// File: rtl/sq_fwd_search.sv
// Load search: walks the slots from oldest to the load's age, lets a
// younger match overwrite an older one per byte, merges over memory data
// and raises the unknown flag for an older slot without an address.
// Assumes ld_age lies between head and tail; otherwise nothing is older.
module sq_fwd_search
    import sq_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int WA_W  = ADDR_W - OFF_W
) (
    input  logic             ld_vld,
    input  logic [WA_W-1:0]  ld_wadr,
    input  logic [LANES-1:0] ld_be,
    input  logic [PTR_W:0]   ld_age,
    input  logic [PTR_W:0]   head,
    input  logic [PTR_W:0]   count,
    input  logic [DW-1:0]    mem_rd_data,
    input  logic             vld_i  [DEPTH],
    input  logic             akn_i  [DEPTH],
    input  logic [WA_W-1:0]  wadr_i [DEPTH],
    input  logic [LANES-1:0] be_i   [DEPTH],
    input  logic [DW-1:0]    data_i [DEPTH],
    output logic [DW-1:0]    ld_data,
    output logic [LANES-1:0] ld_fwd_be,
    output logic             ld_unknown
);
    logic [PTR_W:0]   span;
    logic [PTR_W-1:0] idx;
    logic [DW-1:0]    mdat;
    logic [LANES-1:0] mbe;
    logic             unk;

    // Age-ordered scan: later (younger) hits overwrite earlier ones.
    always_comb begin
        span = ld_age - head;
        if (span > count) span = '0;
        mdat = mem_rd_data;
        mbe  = '0;
        unk  = 1'b0;
        idx  = '0;
        for (int k = 0; k < DEPTH; k++) begin
            idx = head[PTR_W-1:0] + PTR_W'(k);
            if ((PTR_W+1)'(k) < span && vld_i[idx]) begin
                if (!akn_i[idx]) begin
                    unk = 1'b1;
                end else if (wadr_i[idx] == ld_wadr) begin
                    for (int b = 0; b < LANES; b++) begin
                        if (be_i[idx][b] && ld_be[b]) begin
                            mbe[b]         = 1'b1;
                            mdat[8*b +: 8] = data_i[idx][8*b +: 8];
                        end
                    end
                end
            end
        end
        ld_data    = ld_vld ? mdat : mem_rd_data;
        ld_fwd_be  = ld_vld ? mbe  : '0;
        ld_unknown = ld_vld && unk;
    end
endmodule

// File: rtl/store_fwd_queue.sv
// Store queue with store-to-load forwarding. Stores are allocated in
// program order, filled when address and data are ready, and drained to
// memory one per commit from the oldest slot. Loads search it in the
// same cycle. Assumes DEPTH a power of two and accesses inside one word.
module store_fwd_queue
    import sq_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int WA_W  = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_vld,
    output logic              alloc_rdy,
    output logic [PTR_W:0]    alloc_tag,
    input  logic              st_vld,
    input  logic [PTR_W-1:0]  st_slot,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [1:0]        st_size,
    input  logic [DW-1:0]     st_data,
    input  logic              ld_vld,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [1:0]        ld_size,
    input  logic [PTR_W:0]    ld_age,
    input  logic [DW-1:0]     mem_rd_data,
    output logic [DW-1:0]     ld_data,
    output logic [LANES-1:0]  ld_fwd_be,
    output logic              ld_unknown,
    input  logic              cm_go,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [LANES-1:0]  mem_wr_be,
    output logic [DW-1:0]     mem_wr_data,
    input  logic              flush
);
    logic             alloc_fire, full, pop;
    logic [PTR_W:0]   head, tail, count;
    logic [PTR_W-1:0] hidx;
    logic             vld  [DEPTH];
    logic             akn  [DEPTH];
    logic [WA_W-1:0]  wadr [DEPTH];
    logic [LANES-1:0] be   [DEPTH];
    logic [DW-1:0]    data [DEPTH];
    logic [LANES-1:0] st_be, ld_be;

    // Lane masks of the incoming store and load.
    always_comb begin
        st_be = sz_mask(st_addr[OFF_W-1:0], st_size);
        ld_be = sz_mask(ld_addr[OFF_W-1:0], ld_size);
    end

    // Commit drain from the oldest slot.
    always_comb begin
        hidx        = head[PTR_W-1:0];
        pop         = cm_go && vld[hidx] && akn[hidx];
        mem_wr_en   = pop;
        mem_wr_addr = {wadr[hidx], OFF_W'(0)};
        mem_wr_be   = be[hidx];
        mem_wr_data = data[hidx];
        alloc_rdy   = !full;
        alloc_tag   = tail;
    end

    sq_ptr_ctl #(.DEPTH(DEPTH)) i_ptr (
        .clk(clk), .rst_n(rst_n), .alloc_req(alloc_vld), .pop(pop),
        .flush(flush), .alloc_fire(alloc_fire), .full(full),
        .head(head), .tail(tail), .count(count)
    );

    sq_entry_array #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) i_arr (
        .clk(clk), .rst_n(rst_n), .alloc_fire(alloc_fire),
        .alloc_idx(tail[PTR_W-1:0]), .st_vld(st_vld), .st_idx(st_slot),
        .st_wadr(st_addr[ADDR_W-1:OFF_W]), .st_be(st_be), .st_data(st_data),
        .pop(pop), .pop_idx(hidx), .flush(flush),
        .vld_o(vld), .akn_o(akn), .wadr_o(wadr), .be_o(be), .data_o(data)
    );

    sq_fwd_search #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) i_srch (
        .ld_vld(ld_vld), .ld_wadr(ld_addr[ADDR_W-1:OFF_W]), .ld_be(ld_be),
        .ld_age(ld_age), .head(head), .count(count), .mem_rd_data(mem_rd_data),
        .vld_i(vld), .akn_i(akn), .wadr_i(wadr), .be_i(be), .data_i(data),
        .ld_data(ld_data), .ld_fwd_be(ld_fwd_be), .ld_unknown(ld_unknown)
    );
endmodule

// File: rtl/sq_checker.sv
// Port-level properties of the store queue, bound to every instance.
module sq_checker
    import sq_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int TW    = PTR_W + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             alloc_vld,
    input logic             alloc_rdy,
    input logic [TW-1:0]    alloc_tag,
    input logic             ld_vld,
    input logic [OFF_W-1:0] ld_off,
    input logic [1:0]       ld_size,
    input logic [DW-1:0]    mem_rd_data,
    input logic [DW-1:0]    ld_data,
    input logic [LANES-1:0] ld_fwd_be,
    input logic             ld_unknown,
    input logic             cm_go,
    input logic             mem_wr_en,
    input logic [LANES-1:0] mem_wr_be,
    input logic             flush
);
    // R2: an accepted allocation steps the tag by one, wrapping.
    p_tag_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_vld && alloc_rdy && !flush) |=> alloc_tag == TW'($past(alloc_tag) + 1'b1));

    // R2: a request while full leaves the tag unchanged.
    p_full_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_vld && !alloc_rdy && !flush) |=> $stable(alloc_tag));

    // R4: forwarded lanes lie inside the load's own lanes.
    p_fwd_inside_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ld_vld |-> (ld_fwd_be & ~sz_mask(ld_off, ld_size)) == '0);

    // R6: every lane not forwarded carries the memory byte.
    p_mem_bytes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((ld_data ^ mem_rd_data) & ~be2bits(ld_fwd_be)) == '0);

    // R8: memory is written only on commit and with some lane enabled.
    p_drain_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> (cm_go && mem_wr_be != '0));

    // R9: after a flush there is room to allocate.
    p_flush_room_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> alloc_rdy);

    // R10: an idle load port reports nothing.
    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_vld |-> (ld_fwd_be == '0 && !ld_unknown));
endmodule

bind store_fwd_queue sq_checker #(.DEPTH(DEPTH)) i_chk (
    .clk(clk), .rst_n(rst_n), .alloc_vld(alloc_vld), .alloc_rdy(alloc_rdy),
    .alloc_tag(alloc_tag), .ld_vld(ld_vld), .ld_off(ld_addr[2:0]),
    .ld_size(ld_size), .mem_rd_data(mem_rd_data), .ld_data(ld_data),
    .ld_fwd_be(ld_fwd_be), .ld_unknown(ld_unknown), .cm_go(cm_go),
    .mem_wr_en(mem_wr_en), .mem_wr_be(mem_wr_be), .flush(flush)
);

// File: tb/test_store_fwd_queue.sv
module test_store_fwd_queue;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        alloc_vld, alloc_rdy;
    logic [3:0]  alloc_tag;
    logic        st_vld;
    logic [2:0]  st_slot;
    logic [31:0] st_addr;
    logic [1:0]  st_size;
    logic [63:0] st_data;
    logic        ld_vld;
    logic [31:0] ld_addr;
    logic [1:0]  ld_size;
    logic [3:0]  ld_age;
    logic [63:0] mem_rd_data, ld_data;
    logic [7:0]  ld_fwd_be;
    logic        ld_unknown;
    logic        cm_go, mem_wr_en;
    logic [31:0] mem_wr_addr;
    logic [7:0]  mem_wr_be;
    logic [63:0] mem_wr_data;
    logic        flush;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    localparam logic [63:0] MEMV = 64'hA0A1A2A3_A4A5A6A7;

    typedef struct packed {
        logic [31:0] addr;
        logic [1:0]  sz;
        logic [3:0]  age;
        logic [63:0] exp;
        logic [7:0]  be;
        logic        unk;
    } vec_t;

    // Load vectors over stores S0..S3 (R3 R4 R5 R6).
    localparam vec_t VT [11] = '{
        '{32'h100, 2'd3, 4'd4, 64'h22222222_33331111, 8'hFF, 1'b0},
        '{32'h100, 2'd3, 4'd1, 64'h11111111_11111111, 8'hFF, 1'b0},
        '{32'h100, 2'd3, 4'd0, MEMV,                  8'h00, 1'b0},
        '{32'h104, 2'd2, 4'd2, 64'h22222222_A4A5A6A7, 8'hF0, 1'b0},
        '{32'h200, 2'd3, 4'd4, 64'hA0A1A2A3_A4A5A644, 8'h01, 1'b0},
        '{32'h201, 2'd0, 4'd4, MEMV,                  8'h00, 1'b0},
        '{32'h300, 2'd3, 4'd4, MEMV,                  8'h00, 1'b0},
        '{32'h103, 2'd0, 4'd3, 64'hA0A1A2A3_33A5A6A7, 8'h08, 1'b0},
        '{32'h106, 2'd1, 4'd3, 64'h2222A2A3_A4A5A6A7, 8'hC0, 1'b0},
        '{32'h101, 2'd2, 4'd4, 64'hA0A1A2A3_33331111, 8'h0F, 1'b0},
        '{32'h100, 2'd1, 4'd3, 64'hA0A1A2A3_A4A51111, 8'h03, 1'b0}
    };

    store_fwd_queue i_store_fwd_queue (
        .clk(clk), .rst_n(rst_n), .alloc_vld(alloc_vld), .alloc_rdy(alloc_rdy),
        .alloc_tag(alloc_tag), .st_vld(st_vld), .st_slot(st_slot),
        .st_addr(st_addr), .st_size(st_size), .st_data(st_data),
        .ld_vld(ld_vld), .ld_addr(ld_addr), .ld_size(ld_size), .ld_age(ld_age),
        .mem_rd_data(mem_rd_data), .ld_data(ld_data), .ld_fwd_be(ld_fwd_be),
        .ld_unknown(ld_unknown), .cm_go(cm_go), .mem_wr_en(mem_wr_en),
        .mem_wr_addr(mem_wr_addr), .mem_wr_be(mem_wr_be),
        .mem_wr_data(mem_wr_data), .flush(flush)
    );

    always #4ns clk = ~clk;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_alloc();
        alloc_vld = 1'b1;
        tick();
        alloc_vld = 1'b0;
    endtask

    task automatic do_fill(input logic [2:0] s, input logic [31:0] a,
                           input logic [1:0] z, input logic [63:0] d);
        st_vld = 1'b1; st_slot = s; st_addr = a; st_size = z; st_data = d;
        tick();
        st_vld = 1'b0;
    endtask

    task automatic do_load(input logic [31:0] a, input logic [1:0] z, input logic [3:0] g);
        ld_vld = 1'b1; ld_addr = a; ld_size = z; ld_age = g;
        #1;
    endtask

    task automatic do_commit(input string req, input logic en, input logic [31:0] a,
                             input logic [7:0] b, input logic [63:0] d);
        cm_go = 1'b1;
        #1;
        chk(req, 64'(mem_wr_en), 64'(en));
        if (en) begin
            chk(req, 64'(mem_wr_addr), 64'(a));
            chk(req, 64'(mem_wr_be), 64'(b));
            chk(req, mem_wr_data, d);
        end
        tick();
        cm_go = 1'b0;
    endtask

    initial begin
        #(8ns * 100000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; alloc_vld = 1'b0; st_vld = 1'b0; st_slot = '0; st_addr = '0;
        st_size = '0; st_data = '0; ld_vld = 1'b0; ld_addr = '0; ld_size = '0;
        ld_age = '0; mem_rd_data = MEMV; cm_go = 1'b0; flush = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        #1;
        // R1: empty after reset
        chk("R1 rdy", 64'(alloc_rdy), 64'd1);
        chk("R1 tag", 64'(alloc_tag), 64'd0);
        do_commit("R1 commit on empty", 1'b0, '0, '0, '0);

        // R2 R3: four stores, S2 carries junk outside its lanes
        repeat (4) do_alloc();
        #1 chk("R2 tag after four", 64'(alloc_tag), 64'd4);
        do_fill(3'd0, 32'h100, 2'd3, 64'h11111111_11111111);
        do_fill(3'd1, 32'h104, 2'd2, 64'h22222222_00000000);
        do_fill(3'd2, 32'h102, 2'd1, 64'hFFFFFFFF_3333FFFF);
        do_fill(3'd3, 32'h200, 2'd0, 64'h00000000_00000044);

        // R4 R5 R6 R3: vector table
        for (int i = 0; i < 11; i++) begin
            do_load(VT[i].addr, VT[i].sz, VT[i].age);
            chk($sformatf("R4 R5 R6 vec %0d data", i), ld_data, VT[i].exp);
            chk($sformatf("R4 R3 vec %0d be", i), 64'(ld_fwd_be), 64'(VT[i].be));
            chk($sformatf("R7 vec %0d unk", i), 64'(ld_unknown), 64'(VT[i].unk));
        end
        ld_vld = 1'b0;

        // R7: S4 allocated without an address
        do_alloc();
        do_load(32'h100, 2'd3, 4'd5);
        chk("R7 unknown seen", 64'(ld_unknown), 64'd1);
        chk("R7 no fwd from unknown", ld_data, 64'h22222222_33331111);
        do_load(32'h100, 2'd3, 4'd4);
        chk("R7 unknown is younger", 64'(ld_unknown), 64'd0);
        ld_vld = 1'b0;

        // R2: fill to full, then a refused request
        repeat (3) do_alloc();
        #1;
        chk("R2 full rdy", 64'(alloc_rdy), 64'd0);
        chk("R2 full tag", 64'(alloc_tag), 64'd8);
        do_alloc();
        #1 chk("R2 refused tag", 64'(alloc_tag), 64'd8);

        // R4 R7: forward from S6 across unknown S4 S5
        do_fill(3'd6, 32'h300, 2'd3, 64'h55555555_55555555);
        do_load(32'h300, 2'd3, 4'd8);
        chk("R4 fwd across unknowns", ld_data, 64'h55555555_55555555);
        chk("R7 unknown with fwd", 64'(ld_unknown), 64'd1);
        ld_vld = 1'b0;

        // R8: in-order drain
        do_commit("R8 S0", 1'b1, 32'h100, 8'hFF, 64'h11111111_11111111);
        #1 chk("R8 slot freed", 64'(alloc_rdy), 64'd1);
        do_load(32'h100, 2'd3, 4'd4);
        chk("R8 R4 after drain", ld_data, 64'h22222222_3333A6A7);
        chk("R8 R4 be after drain", 64'(ld_fwd_be), 64'hFC);
        ld_vld = 1'b0;
        do_commit("R8 S1", 1'b1, 32'h100, 8'hF0, 64'h22222222_00000000);
        do_commit("R8 R3 S2", 1'b1, 32'h100, 8'h0C, 64'h00000000_33330000);
        do_commit("R8 S3", 1'b1, 32'h200, 8'h01, 64'h00000000_00000044);
        do_commit("R8 unknown head", 1'b0, '0, '0, '0);
        do_fill(3'd4, 32'h400, 2'd2, 64'hFFFFFFFF_66666666);
        do_commit("R8 S4 after fill", 1'b1, 32'h400, 8'h0F, 64'h00000000_66666666);

        // R9: flush, then reuse of a slot that once had an address
        flush = 1'b1;
        tick();
        flush = 1'b0;
        #1 chk("R9 tag at head", 64'(alloc_tag), 64'd5);
        do_alloc();
        do_alloc();
        do_load(32'h300, 2'd3, 4'd7);
        chk("R9 stale data gone", ld_data, MEMV);
        chk("R9 stale be gone", 64'(ld_fwd_be), 64'd0);
        chk("R9 fresh unknown", 64'(ld_unknown), 64'd1);

        // R10: idle load port
        ld_vld = 1'b0;
        #1;
        chk("R10 idle be", 64'(ld_fwd_be), 64'd0);
        chk("R10 idle unk", 64'(ld_unknown), 64'd0);
        chk("R10 idle data", ld_data, MEMV);

        // R1: reset in mid-run
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        #1;
        chk("R1 rdy after reset", 64'(alloc_rdy), 64'd1);
        chk("R1 tag after reset", 64'(alloc_tag), 64'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule